// File: doc/BRIEF.md
# Mode-Selected Arithmetic Logic Unit

This block is a purely combinational n-bit arithmetic logic unit for a register-transfer datapath. It takes two operands, a carry input, one mode bit and a two-bit function code, and returns a result word and a carry output. In arithmetic mode a single ripple adder forms the sum of operand A, a reshaped copy of operand B, and the carry input. The function code reshapes B per bit into zero, B, the complement of B, or all ones. The carry input acts as a third function bit, so the adder alone covers eight arithmetic operations. In logic mode a bitwise section forms one of four Boolean results.

The word is built from identical one-bit stages, repeated by a generate loop for the width parameter. Each stage holds the B shaper, a full adder, a logic cell and the mode selector. The stages are chained through their carries. The block has no clock, no state and no registers, so the state-register and state-naming parts of the house style do not apply.

Top module: `alu_mode_core`

## Requirements
- R1: `mode_logic` = 0 selects arithmetic mode and `mode_logic` = 1 selects logic mode, for the same operands and function code.
- R2: In arithmetic mode, `{carry_out, result}` equals `opnd_a + Y + carry_in`, taken modulo 2^(W+1).
- R3: In arithmetic mode, Y is chosen by `func_sel`: 2'b00 gives zero, 2'b01 gives `opnd_b`, 2'b10 gives `~opnd_b`, and 2'b11 gives all ones.
- R4: `{func_sel, carry_in}` picks one of eight arithmetic results: 000 gives A, 001 gives A+1, 010 gives A+B, 011 gives A+B+1, 100 gives A+~B, 101 gives A−B, 110 gives A−1, and 111 gives A.
- R5: In logic mode, `func_sel` 2'b00 gives A AND B, 2'b01 gives A OR B, 2'b10 gives A XOR B, and 2'b11 gives NOT A.
- R6: In logic mode, `carry_out` is 0 and `carry_in` has no effect on `result`.
- R7: A carry generated in bit 0 ripples through every stage. For example, all-ones A plus one gives a zero result with `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | Operand A (adder X input and logic operand) |
| opnd_b | input | W | Operand B, shaped per bit in arithmetic mode |
| carry_in | input | 1 | Adder carry input; acts as a third function bit |
| mode_logic | input | 1 | 0 selects arithmetic mode, 1 selects logic mode |
| func_sel | input | 2 | Function code within the selected mode |
| result | output | W | Result word |
| carry_out | output | 1 | Adder carry output; 0 in logic mode |

## Verification
The hardest case to reach from the ports is a carry that is generated in the lowest stage and propagates through every stage to the output. This needs all-ones operands together with an increment, or a subtraction at the borrow boundary. At the default width of 4 bits, the bench sweeps every combination of operands, carry input, mode and function code. This covers every full-length ripple and every borrow case, and it also covers logic mode with both values of the unused carry input.

// File: rtl/alu_mode_pkg.sv
package alu_mode_pkg;

    typedef enum logic [1:0] {
        SHAPE_ZERO = 2'b00,
        SHAPE_PASS = 2'b01,
        SHAPE_INV  = 2'b10,
        SHAPE_ONES = 2'b11
    } shape_sel_e;

    typedef enum logic [1:0] {
        BOOL_AND = 2'b00,
        BOOL_OR  = 2'b01,
        BOOL_XOR = 2'b10,
        BOOL_NOT = 2'b11
    } bool_sel_e;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } alu_mode_e;

endpackage

// File: rtl/alu_logic_cell.sv
module alu_logic_cell
    import alu_mode_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic [1:0] func_sel,
    output logic       f_bit
);

    bool_sel_e op;
    assign op = bool_sel_e'(func_sel);

    always_comb begin
        unique case (op)
            BOOL_AND: f_bit = a_bit & b_bit;
            BOOL_OR:  f_bit = a_bit | b_bit;
            BOOL_XOR: f_bit = a_bit ^ b_bit;
            BOOL_NOT: f_bit = ~a_bit;
            default:  f_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_mode_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       c_in,
    input  logic       mode_logic,
    input  logic [1:0] func_sel,
    output logic       f_bit,
    output logic       c_out
);

    logic y_bit;
    logic sum_bit;
    logic bool_bit;

    // B shaper: select 0, B, ~B or 1
    assign y_bit = (b_bit & func_sel[0]) | (~b_bit & func_sel[1]);

    // full adder
    assign sum_bit = a_bit ^ y_bit ^ c_in;
    assign c_out   = (a_bit & y_bit) | (a_bit & c_in) | (y_bit & c_in);

    alu_logic_cell u_logic (
        .a_bit    (a_bit),
        .b_bit    (b_bit),
        .func_sel (func_sel),
        .f_bit    (bool_bit)
    );

    always_comb begin
        unique case (alu_mode_e'(mode_logic))
            MODE_ARITH: f_bit = sum_bit;
            MODE_LOGIC: f_bit = bool_bit;
            default:    f_bit = sum_bit;
        endcase
    end

endmodule

// File: rtl/alu_mode_core.sv
module alu_mode_core
    import alu_mode_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         carry_in,
    input  logic         mode_logic,
    input  logic [1:0]   func_sel,
    output logic [W-1:0] result,
    output logic         carry_out
);

    localparam int CHAIN = W + 1;

    logic [CHAIN-1:0] carry_chain;

    assign carry_chain[0] = carry_in;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_bit      (opnd_a[i]),
            .b_bit      (opnd_b[i]),
            .c_in       (carry_chain[i]),
            .mode_logic (mode_logic),
            .func_sel   (func_sel),
            .f_bit      (result[i]),
            .c_out      (carry_chain[i+1])
        );
    end

    // carries carry meaning only in arithmetic mode
    assign carry_out = mode_logic ? 1'b0 : carry_chain[W];

    // ---------------- assertions ----------------
    logic [W-1:0] chk_y;
    logic [W:0]   chk_sum;

    always_comb begin
        unique case (shape_sel_e'(func_sel))
            SHAPE_ZERO: chk_y = '0;
            SHAPE_PASS: chk_y = opnd_b;
            SHAPE_INV:  chk_y = ~opnd_b;
            SHAPE_ONES: chk_y = '1;
            default:    chk_y = '0;
        endcase
        chk_sum = {1'b0, opnd_a} + {1'b0, chk_y} + {{W{1'b0}}, carry_in};
    end

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, carry_in, mode_logic, func_sel})) begin
            // R2, R3, R4
            if (!mode_logic)
                a_r2_arith_sum: assert ({carry_out, result} == chk_sum)
                    else $error("R2 arithmetic sum mismatch");
            // R5
            if (mode_logic && func_sel == 2'b00)
                a_r5_and: assert (result == (opnd_a & opnd_b)) else $error("R5 AND");
            if (mode_logic && func_sel == 2'b01)
                a_r5_or: assert (result == (opnd_a | opnd_b)) else $error("R5 OR");
            if (mode_logic && func_sel == 2'b10)
                a_r5_xor: assert (result == (opnd_a ^ opnd_b)) else $error("R5 XOR");
            if (mode_logic && func_sel == 2'b11)
                a_r5_not: assert (result == ~opnd_a) else $error("R5 NOT");
            // R6
            if (mode_logic)
                a_r6_no_carry: assert (carry_out == 1'b0) else $error("R6 carry in logic mode");
        end
    end

endmodule

// File: tb/tb_alu_mode_core.sv
module tb_alu_mode_core;

    localparam int W = 4;
    localparam int CLK_PERIOD = 10;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         carry_in = 1'b0;
    logic         mode_logic = 1'b0;
    logic [1:0]   func_sel = 2'b00;
    logic [W-1:0] result;
    logic         carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_mode_core #(.W(W)) dut (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .carry_in   (carry_in),
        .mode_logic (mode_logic),
        .func_sel   (func_sel),
        .result     (result),
        .carry_out  (carry_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s a=%0d b=%0d cin=%0d mode=%0d sel=%0d actual=%0d expected=%0d",
                     tag, opnd_a, opnd_b, carry_in, mode_logic, func_sel, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input int c, input int m, input int s);
        @(posedge clk);
        opnd_a     = a[W-1:0];
        opnd_b     = b[W-1:0];
        carry_in   = c[0];
        mode_logic = m[0];
        func_sel   = s[1:0];
        @(negedge clk);
    endtask

    function automatic int exp_arith(input int a, input int b, input int c, input int s);
        int y;
        case (s)
            0: y = 0;
            1: y = b;
            2: y = (N - 1) - b;
            default: y = N - 1;
        endcase
        return (a + y + c) % (2 * N);
    endfunction

    function automatic int exp_logic(input int a, input int b, input int s);
        case (s)
            0: return a & b;
            1: return a | b;
            2: return a ^ b;
            default: return (N - 1) - a;
        endcase
    endfunction

    initial begin
        // idle state with all inputs low: A + 0 + 0 = 0
        @(negedge clk);
        check("R2 idle result", result, 0);
        check("R2 idle carry", carry_out, 0);

        // R7: full-length ripple and borrow corners
        apply(N - 1, 0, 1, 0, 0);
        check("R7 ones+1 result", result, 0);
        check("R7 ones+1 carry", carry_out, 1);
        apply(0, 1, 1, 0, 2);   // 0 - 1
        check("R7 borrow result", result, N - 1);
        check("R7 borrow carry", carry_out, 0);
        apply(N - 1, N - 1, 1, 0, 1);
        check("R7 ones+ones+1", {carry_out, result}, 2 * N - 1);

        // R1: same inputs, both modes
        apply(5, 3, 0, 0, 1);
        check("R1 arith A+B", result, 8);
        apply(5, 3, 0, 1, 1);
        check("R1 logic A|B", result, 7);

        // exhaustive sweep: R2, R3, R4 (arith) and R5, R6 (logic)
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < N; a++)
                        for (int b = 0; b < N; b++) begin
                            apply(a, b, c, m, s);
                            if (m == 0) begin
                                check("R4 R3 R2 arith", {carry_out, result},
                                      exp_arith(a, b, c, s));
                            end else begin
                                check("R5 logic", result, exp_logic(a, b, s));
                                check("R6 carry zero", carry_out, 0);
                            end
                        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule